// File: doc/BRIEF.md
# Scalar Reduction Loop Sequencer

This block steps the element loop of a vector instruction and hands one element at a time to an external ALU through a ready/valid pair. Each issued element carries an element index and the current accumulator value. The ALU answers through a second ready/valid pair. The returned value is stored as the new accumulator, so the next element sees the result of the one before it. When the destination is a single scalar register, this turns a scalar operation into a sequential map-reduce chain.

A scalar destination normally ends the loop after the first element. Two things keep it running over the whole vector length: the reduce enable, and the data-dependent fail-first enable, which implies reduce behaviour. A vector destination always walks every element. The reverse flag walks the elements from the highest index down to zero. The start pulse loads the initial accumulator. The accumulator is presented as the result, and done pulses once when the loop has finished.

Top module: `redloop_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, `busy_o`, `done_o`, `issue_valid_o` and `res_ready_o` are 0 and `result_o` is 0.
- R2: A start accepted while idle loads `acc_init_i` into the accumulator. The first issued element presents that value on `issue_acc_o`.
- R3: With `dst_scalar_i`=0, exactly VL elements are issued, with indices 0,1,...,VL-1 when `reverse_i`=0.
- R4: With `dst_scalar_i`=1 and both `reduce_en_i` and `ffirst_en_i` at 0, exactly one element is issued, and its result becomes `result_o`.
- R5: With `dst_scalar_i`=1 and `reduce_en_i`=1, VL elements are issued. Each issue carries the previous element's result on `issue_acc_o`, and `result_o` ends as the last element's result.
- R6: With `dst_scalar_i`=1 and `ffirst_en_i`=1, the loop runs all VL elements, the same as with reduce enabled.
- R7: With `reverse_i`=1, element indices run VL-1, VL-2, ..., 0. A single-element scalar loop then issues only index VL-1.
- R8: A start with VL=0 issues no element, keeps `busy_o` at 0, pulses `done_o` in the following cycle and leaves `result_o` equal to `acc_init_i`.
- R9: At most one element is outstanding. After an issue handshake, no new issue happens until the result handshake. `issue_valid_o` and `res_ready_o` are never both 1.
- R10: While `issue_valid_o`=1 and `issue_ready_i`=0, `issue_idx_o` and `issue_acc_o` hold their values.
- R11: `done_o` is a one-cycle pulse in the cycle after the final result handshake. `busy_o` falls in that same cycle, and `result_o` holds until the next start.
- R12: A start pulse while `busy_o`=1 is ignored: the running loop's indices, count and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| vl_i | input | VLW | Vector length |
| reduce_en_i | input | 1 | Reduce mode enable |
| ffirst_en_i | input | 1 | Data-dependent fail-first enable (implies reduce) |
| reverse_i | input | 1 | Walk elements from VL-1 down to 0 |
| dst_scalar_i | input | 1 | Destination register is scalar |
| acc_init_i | input | DW | Initial accumulator value |
| issue_valid_o | output | 1 | Element issue valid |
| issue_ready_i | input | 1 | ALU accepts the element |
| issue_idx_o | output | VLW | Element index |
| issue_acc_o | output | DW | Accumulator operand for the element |
| res_valid_i | input | 1 | ALU result valid |
| res_ready_o | output | 1 | Sequencer accepts the result |
| res_data_i | input | DW | ALU result |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DW | Accumulator / final result |

## Verification
The assertions check the handshake rules on every cycle:
- only one element is outstanding, and the two handshakes never overlap;
- the issued operands stay stable while the ALU stalls;
- each accepted result becomes the accumulator in the next cycle;
- done is a single pulse that arrives with busy low;
- a zero-length start completes at once;
- a start during a run does not end the run.

Only the bench's scenarios can show that the mode flags decide the element count and the index order, and that a chain of additions reaches the expected final sum. These scenarios are driven under random ALU stalls and compared against the cycle model.

// File: rtl/redloop_pkg.sv
package redloop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } rl_state_t;
endpackage

// File: rtl/redloop_ctl.sv
module redloop_ctl
  import redloop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic vl_zero_i,
  input  logic issue_ready_i,
  input  logic res_valid_i,
  input  logic last_i,
  output logic accept_o,
  output logic step_o,
  output logic take_o,
  output logic issue_valid_o,
  output logic res_ready_o,
  output logic busy_o,
  output logic done_o
);
  rl_state_t state_q, state_d;
  logic      done_q, done_d;

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    accept_o = 1'b0;
    take_o   = 1'b0;
    step_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          if (vl_zero_i) done_d = 1'b1;
          else           state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (issue_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (res_valid_i) begin
          take_o = 1'b1;
          if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            step_o  = 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign issue_valid_o = (state_q == ST_ISSUE);
  assign res_ready_o   = (state_q == ST_WAIT);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
endmodule

// File: rtl/redloop_idx.sv
module redloop_idx #(
  parameter int VLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           reverse_i,
  input  logic           single_i,
  output logic [VLW-1:0] idx_o,
  output logic           last_o
);
  localparam logic [VLW-1:0] ONE = VLW'(1);

  logic [VLW-1:0] idx_q, idx_d;
  logic [VLW-1:0] left_q, left_d;
  logic           down_q, down_d;
  logic           en;

  assign en = load_i | step_i;

  always_comb begin
    idx_d  = idx_q;
    left_d = left_q;
    down_d = down_q;
    if (load_i) begin
      down_d = reverse_i;
      idx_d  = reverse_i ? (vl_i - ONE) : '0;
      left_d = single_i ? ONE : vl_i;
    end else if (step_i) begin
      idx_d  = down_q ? (idx_q - ONE) : (idx_q + ONE);
      left_d = left_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      left_q <= '0;
      down_q <= 1'b0;
    end else if (en) begin
      idx_q  <= idx_d;
      left_q <= left_d;
      down_q <= down_d;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (left_q == ONE);
endmodule

// File: rtl/redloop_acc.sv
module redloop_acc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          take_i,
  input  logic [DW-1:0] init_i,
  input  logic [DW-1:0] res_i,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] acc_q, acc_d;
  logic          en;

  assign en = load_i | take_i;

  always_comb begin
    acc_d = acc_q;
    if (load_i)      acc_d = init_i;
    else if (take_i) acc_d = res_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/redloop_seq.sv
module redloop_seq #(
  parameter int DW  = 32,
  parameter int VLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           reduce_en_i,
  input  logic           ffirst_en_i,
  input  logic           reverse_i,
  input  logic           dst_scalar_i,
  input  logic [DW-1:0]  acc_init_i,
  output logic           issue_valid_o,
  input  logic           issue_ready_i,
  output logic [VLW-1:0] issue_idx_o,
  output logic [DW-1:0]  issue_acc_o,
  input  logic           res_valid_i,
  output logic           res_ready_o,
  input  logic [DW-1:0]  res_data_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [DW-1:0]  result_o
);
  logic accept, step, take, last, vl_zero, chain, single;
  logic [DW-1:0] acc;

  assign vl_zero = (vl_i == '0);
  // fail-first implies the reduce chain for a scalar destination
  assign chain   = reduce_en_i | ffirst_en_i;
  assign single  = dst_scalar_i & ~chain;

  redloop_ctl u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .vl_zero_i     (vl_zero),
    .issue_ready_i (issue_ready_i),
    .res_valid_i   (res_valid_i),
    .last_i        (last),
    .accept_o      (accept),
    .step_o        (step),
    .take_o        (take),
    .issue_valid_o (issue_valid_o),
    .res_ready_o   (res_ready_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  redloop_idx #(.VLW(VLW)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .step_i    (step),
    .vl_i      (vl_i),
    .reverse_i (reverse_i),
    .single_i  (single),
    .idx_o     (issue_idx_o),
    .last_o    (last)
  );

  redloop_acc #(.DW(DW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .take_i (take),
    .init_i (acc_init_i),
    .res_i  (res_data_i),
    .acc_o  (acc)
  );

  assign issue_acc_o = acc;
  assign result_o    = acc;
endmodule

// File: rtl/redloop_chk.sv
module redloop_chk #(
  parameter int DW  = 32,
  parameter int VLW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [VLW-1:0] vl_i,
  input logic           issue_valid_o,
  input logic           issue_ready_i,
  input logic [VLW-1:0] issue_idx_o,
  input logic [DW-1:0]  issue_acc_o,
  input logic           res_valid_i,
  input logic           res_ready_o,
  input logic [DW-1:0]  res_data_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [DW-1:0]  result_o
);
  // R9
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid_o && res_ready_o));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid_o && issue_ready_i) |=> (res_ready_o && !issue_valid_o));

  // R10
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid_o && !issue_ready_i) |=>
      (issue_valid_o && $stable(issue_idx_o) && $stable(issue_acc_o)));

  // R5
  acc_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready_o && res_valid_i) |=> (result_o == $past(res_data_i)));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && vl_i == '0) |=> (done_o && !busy_o));

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(res_ready_o && res_valid_i)) |=> busy_o);
endmodule

bind redloop_seq redloop_chk #(.DW(DW), .VLW(VLW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .vl_i          (vl_i),
  .issue_valid_o (issue_valid_o),
  .issue_ready_i (issue_ready_i),
  .issue_idx_o   (issue_idx_o),
  .issue_acc_o   (issue_acc_o),
  .res_valid_i   (res_valid_i),
  .res_ready_o   (res_ready_o),
  .res_data_i    (res_data_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .result_o      (result_o)
);

// File: tb/sim_redloop_seq.sv
module sim_redloop_seq;
  localparam int DW  = 32;
  localparam int VLW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [VLW-1:0] vl_i = '0;
  logic           reduce_en_i = 1'b0, ffirst_en_i = 1'b0;
  logic           reverse_i = 1'b0, dst_scalar_i = 1'b0;
  logic [DW-1:0]  acc_init_i = '0;
  logic           issue_valid_o, issue_ready_i = 1'b0;
  logic [VLW-1:0] issue_idx_o;
  logic [DW-1:0]  issue_acc_o;
  logic           res_valid_i = 1'b0, res_ready_o;
  logic [DW-1:0]  res_data_i = '0;
  logic           busy_o, done_o;
  logic [DW-1:0]  result_o;

  always #10 clk = ~clk; // 50 MHz

  redloop_seq #(.DW(DW), .VLW(VLW)) u0 (.*);

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit      m_busy = 0, m_wait = 0, m_done = 0;
  longint  m_acc = 0;
  int      m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_wait = 0; m_done = 0; m_acc = 0; m_q.delete();
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          int n, cnt;
          n = int'(vl_i);
          m_acc = longint'(acc_init_i);
          if (n == 0) m_done = 1;
          else begin
            cnt = (dst_scalar_i && !(reduce_en_i || ffirst_en_i)) ? 1 : n;
            for (int k = 0; k < cnt; k++) m_q.push_back(reverse_i ? n-1-k : k);
            m_busy = 1; m_wait = 0;
          end
        end
      end else if (!m_wait) begin
        if (issue_ready_i) m_wait = 1;
      end else if (res_valid_i) begin
        m_acc = longint'(res_data_i);
        void'(m_q.pop_front());
        m_wait = 0;
        if (m_q.size() == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  // ---------------- ALU model: result = acc + 3*idx + 1 ----------------
  bit            pend = 0;
  logic [DW-1:0] pend_val = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (res_valid_i && res_ready_o) pend = 0;
      if (issue_valid_o && issue_ready_i) begin
        pend = 1;
        pend_val = issue_acc_o + DW'(3*int'(issue_idx_o) + 1);
      end
    end
  end

  always @(negedge clk) begin
    issue_ready_i <= ($urandom % 4) != 0;
    res_valid_i   <= pend && (($urandom % 3) != 0);
    res_data_i    <= pend ? pend_val : DW'($urandom);
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    cyc++;
    chk(busy_o == m_busy, tag, "busy", busy_o, m_busy);
    chk(done_o == m_done, tag, "done", done_o, m_done);
    chk(issue_valid_o == (m_busy && !m_wait), tag, "issue_valid",
        issue_valid_o, m_busy && !m_wait);
    chk(res_ready_o == (m_busy && m_wait), tag, "res_ready",
        res_ready_o, m_busy && m_wait);
    chk(longint'(result_o) == m_acc, tag, "result", result_o, m_acc);
    if (m_busy && !m_wait) begin
      chk(int'(issue_idx_o) == m_q[0], tag, "issue_idx", issue_idx_o, m_q[0]);
      chk(longint'(issue_acc_o) == m_acc, tag, "issue_acc", issue_acc_o, m_acc);
    end
  end

  // ---------------- scenario driver ----------------
  task automatic run(input int vl, input bit red, input bit ff, input bit rev,
                     input bit scal, input int init, input bit poke, input string t);
    longint exp; int cnt;
    tag = t;
    @(negedge clk);
    vl_i = VLW'(vl); reduce_en_i = red; ffirst_en_i = ff; reverse_i = rev;
    dst_scalar_i = scal; acc_init_i = DW'(init); start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      vl_i = VLW'(2); reverse_i = ~rev; acc_init_i = 32'hdead; start_i = 1;
      @(negedge clk);
      start_i = 0; vl_i = VLW'(vl); reverse_i = rev; acc_init_i = DW'(init);
    end
    for (int c = 0; c < 3000 && !done_o; c++) @(negedge clk);
    chk(done_o == 1'b1, t, "done seen", done_o, 1);
    cnt = (vl == 0) ? 0 : ((scal && !(red || ff)) ? 1 : vl);
    exp = init;
    for (int k = 0; k < cnt; k++) exp += 3 * (rev ? vl-1-k : k) + 1;
    chk(longint'(result_o) == exp, t, "final result", result_o, exp);
    @(negedge clk);
    chk(done_o == 1'b0, t, "done one cycle", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && issue_valid_o == 0 && res_ready_o == 0,
        "R1", "idle in reset", busy_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(result_o == '0, "R1", "result after reset", result_o, 0);
    run(5, 0, 0, 0, 0, 0,   0, "R3");
    run(6, 0, 0, 0, 1, 10,  0, "R4");
    run(7, 1, 0, 0, 1, 100, 0, "R5");
    run(1, 1, 0, 0, 1, 7,   0, "R2");
    run(4, 0, 1, 0, 1, 20,  0, "R6");
    run(5, 1, 0, 1, 1, 3,   0, "R7");
    run(3, 0, 0, 1, 1, 9,   0, "R7");
    run(0, 1, 0, 0, 1, 55,  0, "R8");
    run(6, 1, 0, 0, 1, 1,   1, "R12");
    run(8, 0, 0, 1, 0, 0,   0, "R9");
    run(255, 1, 0, 0, 1, 2, 0, "R10");
    tag = "R11";
    repeat (4) @(negedge clk);
    chk(busy_o == 0 && result_o == u0.result_o, "R11", "result holds", busy_o, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule